// File: doc/BRIEF.md
# Tri-State Phase Detector with Lock Monitor

This block compares two pulse streams that arrive synchronous to the system clock. One is the output of the reference divider and the other is the output of the main divider. Its job is to steer a charge pump. When the reference rising edge comes first, the block raises the source enable (`pump_up`). When the divider rising edge comes first, it raises the sink enable (`pump_dn`). When the lagging edge arrives, both enables are high for exactly one cycle, and then the detector returns to rest. A 2-bit current code drives the pump. That code is copied from a request input, and the copy happens only while the detector is at rest, so the pump current never changes in the middle of a correction pulse.

Each comparison produces a phase error measured in clock cycles. This is the distance between the two rising edges, and it is zero when both edges arrive in the same cycle. A lock monitor counts comparisons whose error is below a window of `WIN_CYC` cycles. The default of 50 cycles corresponds to 250 ns at 200 MHz. When `RUN_LEN` such comparisons (default 7) occur in a row, the monitor raises `locked`. A single comparison outside the window clears both the run and the lock.

The `pump_off` input keeps the detector at rest, holds both enables low, and stops the lock monitor with `locked` at 0. The `busy` output tells the divider controller whether the pump is currently active, so it can time its own updates.

The detector state machine has four states:
- IDLE: at rest.
- SOURCE: the reference edge arrived first.
- SINK: the divider edge arrived first.
- CLEAR: both enables are high.

Its transitions are:
- IDLE→SOURCE on a reference edge alone.
- IDLE→SINK on a divider edge alone.
- IDLE→IDLE when both edges arrive together (a zero-error comparison).
- SOURCE→CLEAR on a divider edge.
- SINK→CLEAR on a reference edge.
- CLEAR→IDLE always.
- Any state→IDLE while `pump_off` is high.

Top module: `tri_pfd_lock`

## Requirements
- R1: While `rst_n` is low, `pump_up`, `pump_dn`, `busy` and `locked` are 0, and `isel` equals 2'b00.
- R2: A rising edge on `ref_in` with no edge on `div_in` in the same cycle, seen at rest, makes `pump_up`=1 and `pump_dn`=0 from the next cycle. This holds for as many cycles as separate the two rising edges.
- R3: A rising edge on `div_in` alone, seen at rest, makes `pump_dn`=1 and `pump_up`=0 from the next cycle. This holds until the cycle after the `ref_in` rising edge.
- R4: After the lagging edge, `pump_up` and `pump_dn` are both 1 for exactly one cycle, and both are 0 in the cycle after that.
- R5: Rising edges on both inputs in the same cycle, seen at rest, leave both enables at 0. They count as a comparison with zero phase error.
- R6: `isel` takes the value of `isel_req` only at a clock edge where the detector is at rest both before and after that edge. While `busy` is 1, `isel` holds. The code is passed through unchanged: 00 selects the lowest pump current and 11 the highest.
- R7: `locked` becomes 1 at the edge that completes the `RUN_LEN`-th consecutive comparison whose edge separation is less than `WIN_CYC` cycles. A separation of `WIN_CYC`-1 still counts as inside the window.
- R8: A comparison whose edge separation is `WIN_CYC` cycles or more clears `locked` at the edge that completes it, and restarts the consecutive count from zero.
- R9: One edge after `pump_off` is sampled high, `pump_up`, `pump_dn`, `busy` and `locked` are 0. Edges arriving while `pump_off` is high are ignored. The consecutive count restarts from zero.
- R10: `busy` is 1 exactly while either pump enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference divider output, clock-synchronous |
| div_in | input | 1 | Main divider output, clock-synchronous |
| pump_off | input | 1 | Disables the pump enables and the lock monitor |
| isel_req | input | ISEL_W | Requested charge-pump current code |
| pump_up | output | 1 | Charge-pump source enable |
| pump_dn | output | 1 | Charge-pump sink enable |
| isel | output | ISEL_W | Applied charge-pump current code |
| busy | output | 1 | Pump active (not at rest) |
| locked | output | 1 | Lock indication, 0 while disabled |

## Verification
The checker watches five properties on every cycle:
- The both-high pulse lasts one cycle and only follows a single active enable.
- The current code changes only across an idle edge.
- `pump_off` silences every output one edge later.
- `locked` never rises right after a disabled cycle.

Only the directed scenarios can show the rest:
- The enable width measured against the edge spacing, for either input leading.
- The count of seven in-window comparisons, including the zero-error case.
- The exact window boundary at `WIN_CYC`-1 versus `WIN_CYC`.
- The restart of the count after a disable.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SRC  = 2'd1,
        ST_SNK  = 2'd2,
        ST_CLR  = 2'd3
    } pfd_state_t;

    localparam int CH_REF = 0;
    localparam int CH_DIV = 1;
    localparam int N_CH   = 2;

endpackage

// File: rtl/pfd_edge.sv
module pfd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sig_in;
    end

    assign rise_o = sig_in & ~prev_q;
endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_rise,
    input  logic       div_rise,
    input  logic       pump_off,
    output pfd_state_t state_o,
    output pfd_state_t next_o,
    output logic       up_o,
    output logic       dn_o,
    output logic       measuring_o,
    output logic       cmp_done_o,
    output logic       cmp_zero_o
);
    pfd_state_t state_q;
    pfd_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (pump_off) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ref_rise && !div_rise)      state_d = ST_SRC;
                    else if (div_rise && !ref_rise) state_d = ST_SNK;
                    else                            state_d = ST_IDLE;
                end
                ST_SRC:  if (div_rise) state_d = ST_CLR;
                ST_SNK:  if (ref_rise) state_d = ST_CLR;
                ST_CLR:  state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        up_o        = 1'b0;
        dn_o        = 1'b0;
        measuring_o = 1'b0;
        cmp_done_o  = 1'b0;
        cmp_zero_o  = 1'b0;
        if (!pump_off) begin
            unique case (state_q)
                ST_IDLE: begin
                    cmp_done_o = ref_rise && div_rise;
                    cmp_zero_o = ref_rise && div_rise;
                end
                ST_SRC: begin
                    up_o        = 1'b1;
                    measuring_o = 1'b1;
                    cmp_done_o  = div_rise;
                end
                ST_SNK: begin
                    dn_o        = 1'b1;
                    measuring_o = 1'b1;
                    cmp_done_o  = ref_rise;
                end
                ST_CLR: begin
                    up_o = 1'b1;
                    dn_o = 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign state_o = state_q;
    assign next_o  = state_d;
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
    parameter int WIN_CYC = 50,
    parameter int RUN_LEN = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic measuring,
    input  logic cmp_done,
    input  logic cmp_zero,
    output logic locked_o
);
    localparam int ERR_W = $clog2(WIN_CYC + 2);
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam logic [ERR_W-1:0] ERR_SAT = ERR_W'(WIN_CYC);
    localparam logic [ERR_W-1:0] ERR_WIN = ERR_W'(WIN_CYC);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);
    localparam logic [RUN_W-1:0] RUN_PRE = RUN_W'(RUN_LEN - 1);

    logic [ERR_W-1:0] err_q;
    logic [ERR_W-1:0] err_meas;
    logic [RUN_W-1:0] run_q;
    logic             in_win;

    // cycles spent with one enable active, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !measuring) err_q <= '0;
        else if (err_q != ERR_SAT)         err_q <= err_q + 1'b1;
    end

    assign err_meas = cmp_zero ? '0 : (err_q + 1'b1);
    assign in_win   = err_meas < ERR_WIN;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_q    <= '0;
            locked_o <= 1'b0;
        end else if (cmp_done) begin
            if (in_win) begin
                if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
                if (run_q >= RUN_PRE) locked_o <= 1'b1;
            end else begin
                run_q    <= '0;
                locked_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pfd_isel.sv
module pfd_isel #(
    parameter int              ISEL_W   = 2,
    parameter logic [ISEL_W-1:0] ISEL_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_ok,
    input  logic [ISEL_W-1:0] req,
    output logic [ISEL_W-1:0] cur_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)       cur_o <= ISEL_RST;
        else if (load_ok) cur_o <= req;
    end
endmodule

// File: rtl/tri_pfd_lock.sv
module tri_pfd_lock
    import pfd_pkg::*;
#(
    parameter int WIN_CYC = 50,
    parameter int RUN_LEN = 7,
    parameter int ISEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic              div_in,
    input  logic              pump_off,
    input  logic [ISEL_W-1:0] isel_req,
    output logic              pump_up,
    output logic              pump_dn,
    output logic [ISEL_W-1:0] isel,
    output logic              busy,
    output logic              locked
);
    logic [N_CH-1:0] raw_in;
    logic [N_CH-1:0] rise;
    pfd_state_t      cur_st;
    pfd_state_t      nxt_st;
    logic            measuring;
    logic            cmp_done;
    logic            cmp_zero;
    logic            load_ok;

    assign raw_in[CH_REF] = ref_in;
    assign raw_in[CH_DIV] = div_in;

    for (genvar g = 0; g < N_CH; g++) begin : g_edge
        pfd_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_in (raw_in[g]),
            .rise_o (rise[g])
        );
    end

    pfd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_rise    (rise[CH_REF]),
        .div_rise    (rise[CH_DIV]),
        .pump_off    (pump_off),
        .state_o     (cur_st),
        .next_o      (nxt_st),
        .up_o        (pump_up),
        .dn_o        (pump_dn),
        .measuring_o (measuring),
        .cmp_done_o  (cmp_done),
        .cmp_zero_o  (cmp_zero)
    );

    pfd_lock_mon #(
        .WIN_CYC (WIN_CYC),
        .RUN_LEN (RUN_LEN)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (pump_off),
        .measuring (measuring),
        .cmp_done  (cmp_done),
        .cmp_zero  (cmp_zero),
        .locked_o  (locked)
    );

    assign load_ok = (cur_st == ST_IDLE) && (nxt_st == ST_IDLE);

    pfd_isel #(
        .ISEL_W   (ISEL_W),
        .ISEL_RST ('0)
    ) u_isel (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_ok (load_ok),
        .req     (isel_req),
        .cur_o   (isel)
    );

    assign busy = (cur_st != ST_IDLE);
endmodule

// File: rtl/tri_pfd_lock_chk.sv
module tri_pfd_lock_chk #(
    parameter int ISEL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pump_off,
    input logic              pump_up,
    input logic              pump_dn,
    input logic [ISEL_W-1:0] isel,
    input logic              busy,
    input logic              locked
);
    // R4: the both-high pulse lasts a single cycle
    assert_clear_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_up && pump_dn) |=> (!pump_up && !pump_dn));

    // R4: the both-high pulse only follows a single active enable
    assert_clear_after_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_up && pump_dn) |-> $past(pump_up ^ pump_dn));

    // R6: current code moves only across an idle edge
    assert_isel_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(isel) |-> (!busy && $past(!busy)));

    // R9: disable silences all outputs one edge later
    assert_off_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pump_off |=> (!pump_up && !pump_dn && !busy && !locked));

    // R9: lock never rises straight out of a disabled cycle
    assert_lock_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(!pump_off));
endmodule

bind tri_pfd_lock tri_pfd_lock_chk #(.ISEL_W(ISEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pump_off (pump_off),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn),
    .isel     (isel),
    .busy     (busy),
    .locked   (locked)
);

// File: tb/tri_pfd_lock_bench.sv
`timescale 1ns/1ps
module tri_pfd_lock_bench;
    localparam int WIN = 50;
    localparam int RUN = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       div_in = 1'b0;
    logic       pump_off = 1'b0;
    logic [1:0] isel_req = 2'b00;
    logic       pump_up, pump_dn, busy, locked;
    logic [1:0] isel;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tri_pfd_lock #(.WIN_CYC(WIN), .RUN_LEN(RUN), .ISEL_W(2)) u_tri_pfd_lock (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .div_in(div_in),
        .pump_off(pump_off), .isel_req(isel_req), .pump_up(pump_up),
        .pump_dn(pump_dn), .isel(isel), .busy(busy), .locked(locked)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one comparison; d = edge separation in cycles, 0 = same cycle
    task automatic do_cmp(input bit ref_first, input int d);
        @(negedge clk);
        if (d == 0) begin
            ref_in = 1'b1; div_in = 1'b1;
            @(negedge clk);
            chk("R5 up", pump_up, 0);
            chk("R5 dn", pump_dn, 0);
            chk("R10 busy idle", busy, 0);
        end else begin
            if (ref_first) ref_in = 1'b1; else div_in = 1'b1;
            for (int i = 0; i < d; i++) begin
                @(negedge clk);
                chk(ref_first ? "R2 up" : "R3 up", pump_up, ref_first);
                chk(ref_first ? "R2 dn" : "R3 dn", pump_dn, !ref_first);
                chk("R10 busy run", busy, 1);
            end
            if (ref_first) div_in = 1'b1; else ref_in = 1'b1;
            @(negedge clk);
            chk("R4 both up", pump_up, 1);
            chk("R4 both dn", pump_dn, 1);
            @(negedge clk);
            chk("R4 after up", pump_up, 0);
            chk("R4 after dn", pump_dn, 0);
            chk("R10 busy end", busy, 0);
        end
        ref_in = 1'b0; div_in = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 up", pump_up, 0);
        chk("R1 dn", pump_dn, 0);
        chk("R1 busy", busy, 0);
        chk("R1 locked", locked, 0);
        chk("R1 isel", isel, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_directions;
        do_cmp(1'b1, 4);   // R2
        do_cmp(1'b0, 3);   // R3
        do_cmp(1'b1, 1);   // R2 minimum spacing
        do_cmp(1'b0, 0);   // R5
    endtask

    task automatic t_isel;
        @(negedge clk);
        isel_req = 2'b10;
        @(negedge clk);
        chk("R6 idle load", isel, 2);
        ref_in = 1'b1; isel_req = 2'b11;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R6 hold busy", isel, 2);
        end
        div_in = 1'b1;
        @(negedge clk);
        chk("R6 hold clear", isel, 2);
        ref_in = 1'b0; div_in = 1'b0;
        @(negedge clk);
        chk("R6 hold exit", isel, 2);
        @(negedge clk);
        chk("R6 late load", isel, 3);
    endtask

    task automatic t_lock;
        do_cmp(1'b1, WIN);          // out of window
        chk("R8 start unlocked", locked, 0);
        for (int k = 0; k < RUN - 1; k++) begin
            do_cmp(k[0], (k == 2) ? 0 : 2 + k);
        end
        chk("R7 six not enough", locked, 0);
        do_cmp(1'b1, 5);
        chk("R7 seventh locks", locked, 1);
        do_cmp(1'b0, WIN);
        chk("R8 wide drops", locked, 0);
        for (int k = 0; k < RUN - 1; k++) do_cmp(1'b1, WIN - 1);
        chk("R7 edge six", locked, 0);
        do_cmp(1'b0, WIN - 1);
        chk("R7 edge seventh", locked, 1);
    endtask

    task automatic t_off;
        @(negedge clk);
        pump_off = 1'b1;
        @(negedge clk);
        chk("R9 locked", locked, 0);
        ref_in = 1'b1;
        @(negedge clk);
        chk("R9 up", pump_up, 0);
        chk("R9 dn", pump_dn, 0);
        chk("R9 busy", busy, 0);
        ref_in = 1'b0;
        @(negedge clk);
        pump_off = 1'b0;
        for (int k = 0; k < RUN - 1; k++) do_cmp(1'b0, 2);
        chk("R9 count restarted", locked, 0);
        do_cmp(1'b1, 2);
        chk("R9 relock", locked, 1);
    endtask

    initial begin
        t_reset();
        t_directions();
        t_isel();
        t_lock();
        t_off();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule